// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides when a processor core stops and restarts its clock for two low-power modes. A power-save instruction strobe comes with a one-bit mode code. The idle code gates the CPU clock and leaves the system clock running for peripherals. The deep-sleep code powers the core down and keeps only the wake logic alive. Deep sleep also needs a software arm bit, and that bit is valid only for a short window before the instruction. A release flag and a hold-off counter stop the core from dropping straight back into deep sleep after it wakes.

In idle, any enabled interrupt request or a watchdog timeout restores the clock. An interrupt that arrives together with the power-save instruction is kept pending, and the core wakes only after idle entry is complete. In deep sleep, the core wakes on any of these: a power-on pulse, the active-low master clear, a deep-sleep watchdog timeout, a real-time alarm when that alarm is enabled, or an edge on an external pin. The master clear, the alarm and the pin are asynchronous, so a multi-stage synchronizer samples them. On exit, each source that was active sets its own sticky bit in a status register, and software reads that register to find the cause.

Top module: `lpm_seq`

## Requirements
- R1: After reset: `cpu_clk_en` = 1, `ds_pwrdn` = 0, `wdt_clr` = 0, `arm_q` = 0, `rel_q` = 0, `wake_stat` = 0.
- R2: When a power-save strobe with `psv_mode` = 1 (idle) is sampled in run state, `cpu_clk_en` goes low in the next cycle. In that first gated cycle, `wdt_clr` is high for exactly one cycle.
- R3: In idle, the core wakes when any request has both `irq_req[i]` and `irq_en[i]` set, or when `wdt_to` is high. `cpu_clk_en` returns high in the cycle after that condition is sampled. A request whose enable is clear has no effect.
- R4: An enabled request present in the strobe cycle or in the cycle after it does not stop idle entry. The clock stays gated for exactly two cycles, and then the core wakes without any further event.
- R5: Writing 1 through `arm_wr`/`arm_wdata` sets `arm_q`. If no deep-sleep strobe (`psv_mode` = 0) arrives within ARM_WIN cycles (default 1), hardware clears `arm_q`. A deep-sleep strobe while `arm_q` = 0 is ignored.
- R6: A deep-sleep strobe that is sampled while the core is armed and entry is allowed raises `ds_pwrdn` and gates `cpu_clk_en` in the next cycle. `arm_q` stays set while the core is asleep.
- R7: On deep-sleep exit, `ds_pwrdn` falls, `cpu_clk_en` rises, `arm_q` clears and `rel_q` sets, all on the same edge.
- R8: Deep-sleep entry is refused while `rel_q` = 1. After a `rel_clr` strobe clears `rel_q`, entry is also refused for the next REL_HOLD cycles (default 3). A strobe sampled on the fourth edge after the clear is accepted.
- R9: Writing 1 to the arm bit clears `wake_stat`. Otherwise `wake_stat` changes only on deep-sleep exit; writing 0 to the arm bit leaves it unchanged.
- R10: On exit, each source active in the exit cycle ORs its bit into `wake_stat`: bit 0 power-on, bit 1 master clear, bit 2 deep-sleep watchdog, bit 3 alarm, bit 4 pin. Two sources in the same cycle set both bits.
- R11: `mclr_n` low wakes the core. `rtc_alarm` wakes it only while `rtc_en` = 1. Both act only after the synchronizer, so a change never ends deep sleep on the first edge after it.
- R12: The pin wakes the core only when three conditions hold: `pin_en` was 1 at entry, the pin changes to the level given by `pin_pol` while the core is asleep, and that change is a move into the asserting level. A level already present at entry does not wake the core, and neither does a move to the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| psv_stb | input | 1 | Power-save instruction strobe |
| psv_mode | input | 1 | 1 = idle, 0 = deep sleep |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| rel_clr | input | 1 | Software clear of the release flag |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Per-request enables |
| wdt_to | input | 1 | Watchdog timeout pulse (idle wake) |
| por_pls | input | 1 | Power-on pulse (deep-sleep wake) |
| dswdt_to | input | 1 | Deep-sleep watchdog timeout pulse |
| mclr_n | input | 1 | Asynchronous active-low master clear |
| rtc_alarm | input | 1 | Asynchronous real-time alarm |
| rtc_en | input | 1 | Alarm wake enable |
| pin_in | input | 1 | Asynchronous external wake pin |
| pin_en | input | 1 | Pin wake enable, captured at entry |
| pin_pol | input | 1 | Asserting pin level |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| ds_pwrdn | output | 1 | Deep-sleep power-down indication |
| wdt_clr | output | 1 | Watchdog clear pulse on idle entry |
| arm_q | output | 1 | Arm bit readback |
| rel_q | output | 1 | Release flag readback |
| wake_stat | output | 5 | Sticky wake-source status |

## Verification
The checker tests, on every cycle, the relations between the ports:
- power-down always gates the clock;
- deep-sleep entry always comes from an armed deep-sleep strobe and never happens while the release flag is set;
- exit always disarms the core, sets the release flag and leaves a nonzero cause;
- the arm bit never outlives its window;
- the status register changes only on an arm write or on exit;
- idle entry always completes its gated cycles.

Some behaviour depends on which input pattern is applied, so only the bench scenarios can show it:
- which exact bits get latched;
- the refusal edges of the hold-off counter;
- that the synchronizer delays the wake;
- that a pin level present at entry, a disabled alarm or a disabled request leaves the core asleep or idle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {ST_RUN, ST_ENTER, ST_IDLE, ST_DEEP} lpm_state_e;

   localparam int unsigned SRC_N     = 5;
   localparam int unsigned SRC_POR   = 0;
   localparam int unsigned SRC_MCLR  = 1;
   localparam int unsigned SRC_DSWDT = 2;
   localparam int unsigned SRC_RTC   = 3;
   localparam int unsigned SRC_PIN   = 4;

   localparam logic MODE_DEEP = 1'b0;
   localparam logic MODE_IDLE = 1'b1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int unsigned   W       = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lpm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lpm_arm.sv
module lpm_arm #(
   parameter int unsigned ARM_WIN  = 1,
   parameter int unsigned REL_HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic wr,
   input  logic wdata,
   input  logic take,
   input  logic ds_exit,
   input  logic rel_clr,
   output logic arm_q,
   output logic rel_q,
   output logic ok
);
   localparam int unsigned WW = $clog2(ARM_WIN + 1);
   localparam int unsigned HW = (REL_HOLD > 0) ? $clog2(REL_HOLD + 1) : 1;

   if (ARM_WIN < 1) begin : g_bad_win
      $error("lpm_arm: ARM_WIN must be at least 1");
   end

   logic [WW-1:0] win_q;
   logic          hold_zero;

   // arm bit with its expiry window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         win_q <= '0;
      end else if (ds_exit) begin
         arm_q <= 1'b0;
      end else if (run) begin
         if (wr) begin
            arm_q <= wdata;
            win_q <= WW'(ARM_WIN);
         end else if (arm_q && !take) begin
            if (win_q <= WW'(1)) arm_q <= 1'b0;
            else                 win_q <= win_q - WW'(1);
         end
      end
   end

   // release flag, set on exit, cleared by software
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rel_q <= 1'b0;
      else if (ds_exit)          rel_q <= 1'b1;
      else if (rel_clr && rel_q) rel_q <= 1'b0;
   end

   if (REL_HOLD == 0) begin : g_no_hold
      assign hold_zero = 1'b1;
   end else begin : g_hold
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   hold_q <= '0;
         else if (rel_clr && rel_q)    hold_q <= HW'(REL_HOLD);
         else if (hold_q != '0)        hold_q <= hold_q - HW'(1);
      end
      assign hold_zero = (hold_q == '0);
   end

   assign ok = arm_q && !rel_q && hold_zero;
endmodule

// File: rtl/lpm_wake.sv
module lpm_wake
   import lpm_pkg::*;
#(
   parameter bit RTC_PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_deep,
   input  logic             entry,
   input  logic             por_pls,
   input  logic             dswdt_to,
   input  logic             mclr_s,
   input  logic             alarm_s,
   input  logic             rtc_en,
   input  logic             pin_s,
   input  logic             pin_en,
   input  logic             pin_pol,
   output logic [SRC_N-1:0] src
);
   logic pin_arm_q;
   logic pin_d_q;
   logic pin_hit;
   logic rtc_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_arm_q <= 1'b0;
         pin_d_q   <= 1'b0;
      end else begin
         pin_d_q <= pin_s;
         if (entry) pin_arm_q <= pin_en;
      end
   end

   // edge into the asserting level, seen after synchronization
   assign pin_hit = pin_arm_q && (pin_s == pin_pol) && (pin_d_q != pin_pol);

   if (RTC_PRESENT) begin : g_rtc
      assign rtc_hit = alarm_s && rtc_en;
   end else begin : g_no_rtc
      logic unused_rtc;
      assign unused_rtc = alarm_s ^ rtc_en;
      assign rtc_hit    = 1'b0;
   end

   always_comb begin
      src            = '0;
      src[SRC_POR]   = por_pls;
      src[SRC_MCLR]  = !mclr_s;
      src[SRC_DSWDT] = dswdt_to;
      src[SRC_RTC]   = rtc_hit;
      src[SRC_PIN]   = pin_hit;
      if (!in_deep) src = '0;
   end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
#(
   parameter int unsigned N_IRQ       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ARM_WIN     = 1,
   parameter int unsigned REL_HOLD    = 3,
   parameter bit          RTC_PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psv_stb,
   input  logic             psv_mode,
   input  logic             arm_wr,
   input  logic             arm_wdata,
   input  logic             rel_clr,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             wdt_to,
   input  logic             por_pls,
   input  logic             dswdt_to,
   input  logic             mclr_n,
   input  logic             rtc_alarm,
   input  logic             rtc_en,
   input  logic             pin_in,
   input  logic             pin_en,
   input  logic             pin_pol,
   output logic             cpu_clk_en,
   output logic             ds_pwrdn,
   output logic             wdt_clr,
   output logic             arm_q,
   output logic             rel_q,
   output logic [SRC_N-1:0] wake_stat
);
   if (N_IRQ < 1) begin : g_bad_irq
      $error("lpm_seq: N_IRQ must be at least 1");
   end

   lpm_state_e       st_q, st_d;
   logic             run, take, go_idle, irq_hit, pend_q, ds_exit, arm_ok;
   logic [2:0]       async_s;
   logic [SRC_N-1:0] src;

   lpm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pin_in, rtc_alarm, mclr_n}),
      .q     (async_s)
   );

   assign run     = (st_q == ST_RUN);
   assign take    = run && psv_stb && (psv_mode == MODE_DEEP) && arm_ok;
   assign go_idle = run && psv_stb && (psv_mode == MODE_IDLE);
   assign irq_hit = |(irq_req & irq_en);
   assign ds_exit = (st_q == ST_DEEP) && (|src);

   lpm_arm #(.ARM_WIN(ARM_WIN), .REL_HOLD(REL_HOLD)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .wr      (arm_wr),
      .wdata   (arm_wdata),
      .take    (take),
      .ds_exit (ds_exit),
      .rel_clr (rel_clr),
      .arm_q   (arm_q),
      .rel_q   (rel_q),
      .ok      (arm_ok)
   );

   lpm_wake #(.RTC_PRESENT(RTC_PRESENT)) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_deep  (st_q == ST_DEEP),
      .entry    (take),
      .por_pls  (por_pls),
      .dswdt_to (dswdt_to),
      .mclr_s   (async_s[0]),
      .alarm_s  (async_s[1]),
      .rtc_en   (rtc_en),
      .pin_s    (async_s[2]),
      .pin_en   (pin_en),
      .pin_pol  (pin_pol),
      .src      (src)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:   if (take) st_d = ST_DEEP; else if (go_idle) st_d = ST_ENTER;
         ST_ENTER: st_d = ST_IDLE;
         ST_IDLE:  if (pend_q || irq_hit || wdt_to) st_d = ST_RUN;
         ST_DEEP:  if (ds_exit) st_d = ST_RUN;
         default:  st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         unique case (st_q)
            ST_RUN:   pend_q <= go_idle && irq_hit;
            ST_ENTER: pend_q <= pend_q || irq_hit;
            default:  pend_q <= 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         wake_stat <= '0;
      else if (run && arm_wr && arm_wdata) wake_stat <= '0;
      else if (ds_exit)                   wake_stat <= wake_stat | src;
   end

   assign cpu_clk_en = run;
   assign ds_pwrdn   = (st_q == ST_DEEP);
   assign wdt_clr    = (st_q == ST_ENTER);
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
   parameter int unsigned ARM_WIN = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       psv_stb,
   input logic       psv_mode,
   input logic       arm_wr,
   input logic       arm_wdata,
   input logic       cpu_clk_en,
   input logic       ds_pwrdn,
   input logic       wdt_clr,
   input logic       arm_q,
   input logic       rel_q,
   input logic [4:0] wake_stat
);
   localparam int unsigned CW = $clog2(ARM_WIN + 2);
   logic [CW-1:0] armed_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               armed_cnt <= '0;
      else if (!arm_q || !cpu_clk_en || arm_wr) armed_cnt <= '0;
      else if (armed_cnt <= CW'(ARM_WIN))       armed_cnt <= armed_cnt + CW'(1);
   end

   assert_pwrdn_gates_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ds_pwrdn |-> !cpu_clk_en);
   assert_entry_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_pwrdn) |-> $past(arm_q && psv_stb && !psv_mode));
   assert_no_entry_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_pwrdn) |-> !$past(rel_q));
   assert_exit_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ds_pwrdn) |-> (!arm_q && rel_q && cpu_clk_en));
   assert_arm_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && cpu_clk_en) |-> (armed_cnt < CW'(ARM_WIN)));
   assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(arm_wr && arm_wdata && cpu_clk_en) |-> (wake_stat == 5'd0));
   assert_stat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wake_stat) |-> ($fell(ds_pwrdn) || $past(arm_wr && arm_wdata && cpu_clk_en)));
   assert_exit_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ds_pwrdn) |-> (wake_stat != 5'd0));
   assert_wdt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |-> (!cpu_clk_en && $past(psv_stb && psv_mode && cpu_clk_en)));
   assert_entry_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_clr |=> (!cpu_clk_en && !wdt_clr && !ds_pwrdn));
endmodule

bind lpm_seq lpm_seq_chk #(.ARM_WIN(ARM_WIN)) i_lpm_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .psv_stb    (psv_stb),
   .psv_mode   (psv_mode),
   .arm_wr     (arm_wr),
   .arm_wdata  (arm_wdata),
   .cpu_clk_en (cpu_clk_en),
   .ds_pwrdn   (ds_pwrdn),
   .wdt_clr    (wdt_clr),
   .arm_q      (arm_q),
   .rel_q      (rel_q),
   .wake_stat  (wake_stat)
);

// File: tb/test_lpm_seq.sv
module test_lpm_seq;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic psv_stb = 0, psv_mode = 0, arm_wr = 0, arm_wdata = 0, rel_clr = 0;
   logic [N-1:0] irq_req = '0, irq_en = '0;
   logic wdt_to = 0, por_pls = 0, dswdt_to = 0, mclr_n = 1, rtc_alarm = 0, rtc_en = 0;
   logic pin_in = 0, pin_en = 0, pin_pol = 1;
   logic cpu_clk_en, ds_pwrdn, wdt_clr, arm_q, rel_q;
   logic [4:0] wake_stat;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   lpm_seq #(.N_IRQ(N)) i_lpm_seq (
      .clk(clk), .rst_n(rst_n), .psv_stb(psv_stb), .psv_mode(psv_mode),
      .arm_wr(arm_wr), .arm_wdata(arm_wdata), .rel_clr(rel_clr),
      .irq_req(irq_req), .irq_en(irq_en), .wdt_to(wdt_to), .por_pls(por_pls),
      .dswdt_to(dswdt_to), .mclr_n(mclr_n), .rtc_alarm(rtc_alarm), .rtc_en(rtc_en),
      .pin_in(pin_in), .pin_en(pin_en), .pin_pol(pin_pol),
      .cpu_clk_en(cpu_clk_en), .ds_pwrdn(ds_pwrdn), .wdt_clr(wdt_clr),
      .arm_q(arm_q), .rel_q(rel_q), .wake_stat(wake_stat));

   function automatic logic idle_wake(logic [N-1:0] r, logic [N-1:0] e, logic w);
      return (|(r & e)) | w;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic do_arm();
      arm_wr = 1; arm_wdata = 1; step(); arm_wr = 0; arm_wdata = 0;
   endtask

   task automatic go_deep();
      if (rel_q) begin rel_clr = 1; step(); rel_clr = 0; step(4); end
      do_arm();
      psv_stb = 1; psv_mode = 0; step(); psv_stb = 0;
   endtask

   task automatic wait_wake();
      for (int k = 0; k < 8; k++) begin
         if (!ds_pwrdn) break;
         step();
      end
   endtask

   task automatic pulse_por();
      por_pls = 1; step(); por_pls = 0;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] r, e;
      logic w, pend, woke;
      void'($urandom(32'h1a2b3c4d));
      step(3);
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 clk_en", cpu_clk_en, 1); chk("R1 pwrdn", ds_pwrdn, 0);
      chk("R1 wdt_clr", wdt_clr, 0); chk("R1 arm", arm_q, 0);
      chk("R1 rel", rel_q, 0); chk("R1 stat", wake_stat, 0);

      // R5 arm window expiry, unarmed sleep strobe ignored
      do_arm(); chk("R5 armed", arm_q, 1);
      step(); chk("R5 expired", arm_q, 0);
      psv_stb = 1; psv_mode = 0; step(); psv_stb = 0;
      chk("R5 unarmed strobe", ds_pwrdn, 0); chk("R5 clk kept", cpu_clk_en, 1);

      // R6 entry, R7 exit via power-on pulse, R10 bit 0
      go_deep();
      chk("R6 pwrdn", ds_pwrdn, 1); chk("R6 clk off", cpu_clk_en, 0); chk("R6 arm held", arm_q, 1);
      step(3); chk("R6 stays asleep", ds_pwrdn, 1);
      pulse_por();
      chk("R7 pwrdn", ds_pwrdn, 0); chk("R7 clk", cpu_clk_en, 1);
      chk("R7 arm cleared", arm_q, 0); chk("R7 rel set", rel_q, 1);
      chk("R10 por bit", wake_stat, 5'h01);

      // R8 refused while release flag set
      do_arm(); psv_stb = 1; psv_mode = 0; step(); psv_stb = 0;
      chk("R8 refused rel", ds_pwrdn, 0);
      // R8 refused inside hold-off: clear at t0, strobe at t3
      rel_clr = 1; step(); rel_clr = 0; step();
      do_arm(); psv_stb = 1; psv_mode = 0; step(); psv_stb = 0;
      chk("R8 refused hold", ds_pwrdn, 0); chk("R8 rel clear", rel_q, 0);
      do_arm(); psv_stb = 1; psv_mode = 0; step(); psv_stb = 0;
      chk("R8 accepted later", ds_pwrdn, 1);
      dswdt_to = 1; step(); dswdt_to = 0;
      chk("R10 dswdt bit only", wake_stat, 5'h04);
      // R8 accepted exactly at the fourth edge after the clear
      rel_clr = 1; step(); rel_clr = 0; step(2);
      do_arm(); psv_stb = 1; psv_mode = 0; step(); psv_stb = 0;
      chk("R8 boundary accept", ds_pwrdn, 1);

      // R11 master clear via synchronizer
      mclr_n = 0; step();
      chk("R11 sync delay", ds_pwrdn, 1);
      wait_wake();
      chk("R11 mclr woke", ds_pwrdn, 0); chk("R10 mclr bit", wake_stat, 5'h02);
      mclr_n = 1; step(3);

      // R9 sticky status and clear on arm write
      arm_wr = 1; arm_wdata = 0; step(); arm_wr = 0;
      chk("R9 write0 keeps", wake_stat, 5'h02);
      do_arm(); chk("R9 arm clears", wake_stat, 0);
      step();

      // R11 alarm needs enable
      go_deep(); rtc_en = 0; rtc_alarm = 1; step(6);
      chk("R11 alarm disabled", ds_pwrdn, 1);
      rtc_en = 1; wait_wake();
      chk("R11 alarm woke", ds_pwrdn, 0); chk("R10 rtc bit", wake_stat, 5'h08);
      rtc_alarm = 0; rtc_en = 0; step(3);

      // R12 pin: level at entry does not wake, edge does
      pin_pol = 1; pin_en = 1; pin_in = 1; step(3);
      go_deep(); step(6);
      chk("R12 level at entry", ds_pwrdn, 1);
      pin_in = 0; step(4);
      chk("R12 deassert edge", ds_pwrdn, 1);
      pin_in = 1; wait_wake();
      chk("R12 edge woke", ds_pwrdn, 0); chk("R10 pin bit", wake_stat, 5'h10);
      // R12 pin enabled only after entry
      pin_en = 0; go_deep(); pin_en = 1;
      pin_in = 0; step(4); pin_in = 1; step(5);
      chk("R12 late enable", ds_pwrdn, 1);
      pulse_por(); chk("R12 por after", wake_stat, 5'h01);
      // R12 low polarity
      pin_pol = 0; pin_en = 1; go_deep();
      pin_in = 0; wait_wake();
      chk("R12 low pol woke", ds_pwrdn, 0); chk("R12 low pol bit", wake_stat, 5'h10);
      pin_en = 0; step(3);

      // R10 simultaneous sources
      go_deep(); por_pls = 1; dswdt_to = 1; step(); por_pls = 0; dswdt_to = 0;
      chk("R10 two bits", wake_stat, 5'h05);

      // R2/R3 directed idle
      psv_stb = 1; psv_mode = 1; step(); psv_stb = 0;
      chk("R2 clk off", cpu_clk_en, 0); chk("R2 wdt_clr", wdt_clr, 1);
      step(); chk("R2 wdt_clr single", wdt_clr, 0);
      irq_req = 8'h10; irq_en = 8'hEF; step();
      chk("R3 disabled irq", cpu_clk_en, 0);
      irq_req = 0; irq_en = 0; wdt_to = 1; step(); wdt_to = 0;
      chk("R3 wdt wake", cpu_clk_en, 1);

      // R4 coincident interrupt
      irq_req = 8'h01; irq_en = 8'h01; psv_stb = 1; psv_mode = 1; step(); psv_stb = 0;
      irq_req = 0;
      chk("R4 entered", cpu_clk_en, 0);
      step(); chk("R4 idle reached", cpu_clk_en, 0);
      step(); chk("R4 deferred wake", cpu_clk_en, 1);
      irq_en = 0;

      // R3/R4 random idle episodes
      for (int ep = 0; ep < 40; ep++) begin
         r = N'($urandom & $urandom & $urandom); e = N'($urandom);
         irq_req = r; irq_en = e; psv_stb = 1; psv_mode = 1;
         pend = idle_wake(r, e, 1'b0);
         step(); psv_stb = 0;
         chk("R2 rnd gate", cpu_clk_en, 0);
         r = N'($urandom & $urandom & $urandom); e = N'($urandom);
         irq_req = r; irq_en = e; pend |= idle_wake(r, e, 1'b0);
         step(); chk("R4 rnd idle", cpu_clk_en, 0);
         woke = 0;
         for (int k = 0; k < 6 && !woke; k++) begin
            r = N'($urandom & $urandom & $urandom); e = N'($urandom);
            w = (($urandom % 8) == 0);
            irq_req = r; irq_en = e; wdt_to = w;
            woke = pend | idle_wake(r, e, w);
            pend = 0;
            step();
            chk("R3 rnd wake", cpu_clk_en, woke);
         end
         irq_req = 0; irq_en = 0; wdt_to = 0;
         if (!woke) begin
            wdt_to = 1; step(); wdt_to = 0;
            chk("R3 rnd forced", cpu_clk_en, 1);
         end
         step();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule